// File: doc/BRIEF.md
# Pattern Compare and Logic Unit

This block is the combinational 32-bit execution slice of a RISC core that handles the register-register bitwise operations and the pattern compares. The two families share opcodes. The two low opcode bits pick the operation slot, and an 11-bit function field picks the family. An all-zero field selects plain logic: OR, AND, XOR or AND-NOT. A field with only its top bit set selects the compare counterpart of the slot: find-first-matching-byte, nothing, equality or inequality.

Bytes are numbered from the most significant end. Lane 0 is the top byte, `ra[31:24]`. The byte finder scans from lane 0 downward and returns the 1-based index of the first lane where both operands hold the same byte. The decode ahead of this block, the flag updates and the writeback all sit outside it.

Top module: `plu_unit`

## Requirements
- R1: With funcField = 0 and opLow = 2'b00, result equals ra OR rb.
- R2: With funcField = 0 and opLow = 2'b01, result equals ra AND rb.
- R3: With funcField = 0 and opLow = 2'b10, result equals ra XOR rb.
- R4: With funcField = 0 and opLow = 2'b11, result equals ra AND (NOT rb).
- R5: Compare mode is selected only by funcField = 11'b10000000000, with bit 10 set and all other bits clear.
- R6: In compare mode with opLow = 2'b00 (byte-find), the result is the 1-based lane index of the first matching byte. Lane 1 is bits 31:24, lane 2 is bits 23:16, lane 3 is bits 15:8 and lane 4 is bits 7:0. The result is 0 when no lane matches, and the most significant matching lane wins.
- R7: In compare mode with opLow = 2'b10, the result is 1 when ra equals rb and 0 otherwise.
- R8: In compare mode with opLow = 2'b11, the result is 1 when ra differs from rb and 0 otherwise.
- R9: Every compare result is zero-extended, so result bits 31:3 are 0 in compare mode.
- R10: Any funcField value other than the two legal codes, and compare mode with opLow = 2'b01, drive result to 0 and set illegalFunc. Every legal combination clears illegalFunc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opLow | input | 2 | Low two opcode bits, which pick the operation slot |
| funcField | input | 11 | Function field: all zero for logic, bit 10 alone for compare |
| ra | input | 32 | First operand |
| rb | input | 32 | Second operand |
| result | output | 32 | Operation result |
| illegalFunc | output | 1 | High for an unused selector combination |

## Verification
The byte finder is tried with operands that match in no lane, in exactly one lane (each lane in turn), and in several lanes at once. Together these separate a correct MSB-first priority from a reversed or missing one. Equality and inequality are driven with identical words and with words that differ in a single bit at either end, which catches a compare that looks at only part of the word. The logic operations are run on complementary and overlapping patterns that tell the four functions apart, and AND-NOT in particular from AND. Function fields with a stray bit, and the AND slot in compare mode, confirm the illegal path. Random operands fill in the rest.

// File: rtl/plu_pkg.sv
package plu_pkg;
  localparam int FUNC_W = 11;
  localparam logic [FUNC_W-1:0] FUNC_LOGIC = '0;
  localparam logic [FUNC_W-1:0] FUNC_CMP   = {1'b1, {(FUNC_W-1){1'b0}}};

  typedef struct packed {
    logic selOr;
    logic selAnd;
    logic selXor;
    logic selAndn;
    logic selFind;
    logic selEq;
    logic selNe;
  } plu_strobe_t;
endpackage

// File: rtl/plu_ctrl.sv
module plu_ctrl
  import plu_pkg::*;
(
  input  logic [1:0]        opLow,
  input  logic [FUNC_W-1:0] funcField,
  output plu_strobe_t       strobes,
  output logic              illegalFunc
);
  logic logicMode;
  logic cmpMode;

  assign logicMode = (funcField == FUNC_LOGIC);
  assign cmpMode   = (funcField == FUNC_CMP);

  always_comb begin
    strobes = '0;
    if (logicMode) begin
      case (opLow)
        2'b00:   strobes.selOr   = 1'b1;
        2'b01:   strobes.selAnd  = 1'b1;
        2'b10:   strobes.selXor  = 1'b1;
        default: strobes.selAndn = 1'b1;
      endcase
    end else if (cmpMode) begin
      case (opLow)
        2'b00:   strobes.selFind = 1'b1;
        2'b10:   strobes.selEq   = 1'b1;
        2'b11:   strobes.selNe   = 1'b1;
        default: ;
      endcase
    end
  end

  assign illegalFunc = (strobes == '0);

  always_comb begin
    // R10
    strobe_onehot_chk: assert ($onehot0(strobes));
    // R5
    cmp_field_chk: assert (!(strobes.selFind || strobes.selEq || strobes.selNe)
                           || (funcField[FUNC_W-1] && funcField[FUNC_W-2:0] == '0));
  end
endmodule

// File: rtl/plu_datapath.sv
module plu_datapath
  import plu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] ra,
  input  logic [DATA_W-1:0] rb,
  input  plu_strobe_t       strobes,
  output logic [DATA_W-1:0] result
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int IDX_W = $clog2(LANES + 1);

  logic [LANES-1:0] laneHit;
  logic [IDX_W-1:0] findIdx;
  logic             wordEq;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneHit[l] = (ra[DATA_W-1-l*LANE_W -: LANE_W] == rb[DATA_W-1-l*LANE_W -: LANE_W]);
  end

  always_comb begin
    findIdx = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (laneHit[l]) findIdx = IDX_W'(l + 1);
    end
  end

  assign wordEq = &laneHit;

  always_comb begin
    result = '0;
    if (strobes.selOr)   result = ra | rb;
    if (strobes.selAnd)  result = ra & rb;
    if (strobes.selXor)  result = ra ^ rb;
    if (strobes.selAndn) result = ra & ~rb;
    if (strobes.selFind) result = DATA_W'(findIdx);
    if (strobes.selEq)   result = DATA_W'(wordEq);
    if (strobes.selNe)   result = DATA_W'(!wordEq);
  end

  always_comb begin
    // R6
    find_range_chk: assert (findIdx <= IDX_W'(LANES));
    // R6
    find_none_chk: assert ((findIdx != '0) || (ra ^ rb) == ((ra ^ rb) & ~{LANES{ {(LANE_W-1){1'b0}}, 1'b0 }})
                           && laneHit == '0 || findIdx != '0);
    // R7
    eq_lanes_chk: assert (wordEq == (ra == rb));
  end
endmodule

// File: rtl/plu_unit.sv
module plu_unit
  import plu_pkg::*;
(
  input  logic [1:0]  opLow,
  input  logic [10:0] funcField,
  input  logic [31:0] ra,
  input  logic [31:0] rb,
  output logic [31:0] result,
  output logic        illegalFunc
);
  plu_strobe_t strobes;

  plu_ctrl u_ctrl (
    .opLow       (opLow),
    .funcField   (funcField),
    .strobes     (strobes),
    .illegalFunc (illegalFunc)
  );

  plu_datapath #(.DATA_W(32), .LANE_W(8)) u_dp (
    .ra      (ra),
    .rb      (rb),
    .strobes (strobes),
    .result  (result)
  );

  always_comb begin
    // R10
    illegal_zero_chk: assert (!illegalFunc || result == '0);
    // R9
    cmp_extend_chk: assert (!(strobes.selFind || strobes.selEq || strobes.selNe)
                            || result[31:3] == '0);
  end
endmodule

// File: tb/plu_unit_test.sv
module plu_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  opLow = '0;
  logic [10:0] funcField = '0;
  logic [31:0] ra = '0;
  logic [31:0] rb = '0;
  logic [31:0] result;
  logic        illegalFunc;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  plu_unit uut (
    .opLow(opLow), .funcField(funcField), .ra(ra), .rb(rb),
    .result(result), .illegalFunc(illegalFunc)
  );

  function automatic void refModel(input logic [1:0] op, input logic [10:0] fn,
                                   input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] r, output logic ill);
    r = 0; ill = 0;
    if (fn == 11'd0) begin
      case (op)
        2'd0: r = a | b;
        2'd1: r = a & b;
        2'd2: r = a ^ b;
        default: r = a & ~b;
      endcase
    end else if (fn == 11'h400) begin
      if (op == 2'd0) begin
        for (int k = 4; k >= 1; k--)
          if (((a >> (32 - 8*k)) & 32'hff) == ((b >> (32 - 8*k)) & 32'hff)) r = k;
      end else if (op == 2'd2) r = (a == b) ? 1 : 0;
      else if (op == 2'd3) r = (a != b) ? 1 : 0;
      else ill = 1;
    end else ill = 1;
  endfunction

  task automatic apply(input string tag, input logic [1:0] op, input logic [10:0] fn,
                       input logic [31:0] a, input logic [31:0] b);
    logic [31:0] expR;
    logic expI;
    @(posedge clk);
    opLow = op; funcField = fn; ra = a; rb = b;
    @(negedge clk);
    refModel(op, fn, a, b, expR, expI);
    checks++;
    if (result !== expR || illegalFunc !== expI) begin
      fails++;
      $display("FAIL %s: op=%0d fn=%h ra=%h rb=%h actual=%h/%0b expected=%h/%0b",
               tag, op, fn, a, b, result, illegalFunc, expR, expI);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply("reset R1", 2'd0, 11'd0, 32'h0, 32'h0);
    apply("R1", 2'd0, 11'd0, 32'hF0F0_1234, 32'h0F0F_0001);
    apply("R2", 2'd1, 11'd0, 32'hFF00_FF00, 32'h0FF0_0FF0);
    apply("R3", 2'd2, 11'd0, 32'hAAAA_5555, 32'hFFFF_0000);
    apply("R4", 2'd3, 11'd0, 32'hFFFF_FFFF, 32'h0F0F_F0F0);
    apply("R4", 2'd3, 11'd0, 32'h1234_5678, 32'h1234_5678);
    apply("R6 none", 2'd0, 11'h400, 32'h0102_0304, 32'hF1F2_F3F4);
    apply("R6 lane1", 2'd0, 11'h400, 32'hAB00_0000, 32'hAB11_2233);
    apply("R6 lane2", 2'd0, 11'h400, 32'h00CD_0000, 32'h11CD_2233);
    apply("R6 lane3", 2'd0, 11'h400, 32'h0000_EF00, 32'h1122_EF33);
    apply("R6 lane4", 2'd0, 11'h400, 32'h0000_0077, 32'h1122_3377);
    apply("R6 multi", 2'd0, 11'h400, 32'h0055_0066, 32'h1155_2266);
    apply("R6 all R9", 2'd0, 11'h400, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    apply("R7 eq", 2'd2, 11'h400, 32'hCAFE_F00D, 32'hCAFE_F00D);
    apply("R7 msb", 2'd2, 11'h400, 32'h8000_0000, 32'h0000_0000);
    apply("R7 lsb", 2'd2, 11'h400, 32'h0000_0001, 32'h0000_0000);
    apply("R8 eq", 2'd3, 11'h400, 32'h1357_9BDF, 32'h1357_9BDF);
    apply("R8 lsb", 2'd3, 11'h400, 32'h1357_9BDE, 32'h1357_9BDF);
    apply("R10 and-cmp", 2'd1, 11'h400, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R5 R10 stray", 2'd0, 11'h401, 32'hFFFF_FFFF, 32'h1);
    apply("R5 R10 low", 2'd2, 11'h001, 32'h1234, 32'h1234);
    apply("R10 mix", 2'd3, 11'h7FF, 32'h5, 32'h6);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [10:0] fn;
      a = $urandom;
      b = (i % 3 == 0) ? (a ^ (32'hFF << (8 * (i % 4)))) : $urandom;
      fn = (i % 5 == 0) ? 11'($urandom) : ((i % 2 == 0) ? 11'h400 : 11'h000);
      apply("R1 R6 random", 2'($urandom), fn, a, b);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule